// File: doc/BRIEF.md
# Banked Bit-Addressable Scratch RAM

This block is the 128-byte on-chip data store of a small 8-bit controller core. A byte port reads and writes any location, either at the given address or through a pointer held in one of the first two registers of the active bank. A register port reaches the eight working registers of whichever of the four banks is active. A bit port sets, clears or writes single bits in a 16-byte window, and a stack pointer with push, pop and load strobes keeps its stack in the same array.

All storage sits in one flop array, so every access path sees the same bytes. The register banks fill 00H to 1FH, the bit window covers 20H to 2FH, and 30H to 7FH is plain storage. Reads are combinational and writes take effect on the rising clock edge. When several writers target the same byte in one cycle, a fixed priority picks one of them.

Top module: `bitram_core`

## Requirements
- R1: A byte write with `byteInd`=0 stores `byteWrData` at `byteAddr` (00H..7FH) on the rising edge; `byteRdData` shows the addressed byte combinationally, so it shows the old value until that edge.
- R2: An effective byte address of 80H or above, whether given directly or through a pointer, reads as 00H, and a write to it changes no byte.
- R3: With `byteInd`=1 the effective address is the content of byte 8*bank + `byteAddr[0]` (register 0 or 1 of the active bank), for both reads and writes.
- R4: The register port reaches register n (`regSel`) of the active bank at byte 8*bank + n, for reads on `regRdData` and writes with `regWrEn`.
- R5: The active bank (`curBank`) is 0 after reset, is loaded from `bankSel` on an edge where `bankWrEn`=1, and holds otherwise.
- R6: Bit address n (`bitAddr`, 00H..7FH) is bit n mod 8 of byte 20H + n/8; `bitRdData` shows that bit combinationally.
- R7: `bitOp` encodes 00 = none, 01 = set, 10 = clear, 11 = write `bitWrData`; the edge changes only the addressed bit and leaves the other seven bits of the byte intact.
- R8: When a byte write and a bit operation hit the same byte in one cycle, the byte write wins completely.
- R9: The stack pointer (`spOut`) is 07H after reset; a push adds one to it and writes `pushData` at the new value, so the first push after reset lands at 08H.
- R10: `popData` shows the byte at the stack pointer (00H if the pointer is 80H or above); a pop subtracts one from the pointer, which wraps modulo 256.
- R11: `spLoadEn` loads `spLoadData` into the stack pointer and suppresses a push or pop in the same cycle; with push and pop together, the push is taken.
- R12: Every byte reads 00H after reset.
- R13: Among writers to one byte in one cycle the order is byte port, then register port, then push, then bit operation; writers to different bytes all complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| byteAddr | input | 8 | Byte address, or pointer select in bit 0 when indirect |
| byteInd | input | 1 | 1 selects pointer addressing through register 0/1 |
| byteWrEn | input | 1 | Byte write strobe |
| byteWrData | input | 8 | Byte write data |
| byteRdData | output | 8 | Byte read data |
| regSel | input | 3 | Register number within the active bank |
| bankSel | input | 2 | New bank number |
| bankWrEn | input | 1 | Load the active bank from bankSel |
| curBank | output | 2 | Active bank |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data |
| bitAddr | input | 7 | Bit address in the bit window |
| bitOp | input | 2 | Bit operation: none, set, clear, write |
| bitWrData | input | 1 | Value for the bit write operation |
| bitRdData | output | 1 | Addressed bit |
| pushEn | input | 1 | Push strobe |
| pushData | input | 8 | Byte to push |
| popEn | input | 1 | Pop strobe |
| popData | output | 8 | Byte at the stack pointer |
| spLoadEn | input | 1 | Stack pointer load strobe |
| spLoadData | input | 8 | Value loaded into the stack pointer |
| spOut | output | 8 | Current stack pointer |

## Verification
The properties assume every input is a known value at each rising edge, and that inputs change only between edges. The write-then-read property counts on no pointer lookup in the following cycle, and the bit-set property counts on no other writer hitting the same byte in that cycle. The bench changes all inputs on the falling edge, drops every strobe once the edge that uses it has passed, and samples results on the low half of the clock. It mixes writers on one byte only in the scenarios that test priority.

// File: rtl/bitram_pkg.sv
package bitram_pkg;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 8;
  localparam int RAM_BYTES  = 128;
  localparam int RAM_AW     = $clog2(RAM_BYTES);
  localparam int BANK_CNT   = 4;
  localparam int BANK_W     = $clog2(BANK_CNT);
  localparam int REG_CNT    = 8;
  localparam int REG_W      = $clog2(REG_CNT);
  localparam int BIT_BASE   = 32;
  localparam int BIT_BYTES  = 16;
  localparam int BIT_AW     = $clog2(BIT_BYTES * DATA_W);
  localparam int POS_W      = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] SP_INIT = ADDR_W'(7);

  typedef logic [DATA_W-1:0] byte_t;

  typedef enum logic [1:0] {
    BIT_NOP = 2'b00,
    BIT_SET = 2'b01,
    BIT_CLR = 2'b10,
    BIT_PUT = 2'b11
  } bitOp_e;

  // Write strobes handed from control to the datapath
  typedef struct packed {
    logic              byteWe;
    logic [RAM_AW-1:0] byteA;
    byte_t             byteD;
    logic              regWe;
    logic [RAM_AW-1:0] regA;
    byte_t             regD;
    logic              pushWe;
    logic [RAM_AW-1:0] pushA;
    byte_t             pushD;
    logic              bitWe;
    logic [RAM_AW-1:0] bitA;
    logic [POS_W-1:0]  bitPos;
    logic              bitVal;
  } wrStrobes_t;
endpackage

// File: rtl/bitram_dpath.sv
module bitram_dpath
  import bitram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobes_t        wr,
  input  logic [RAM_AW-1:0] ptrA,
  input  logic [RAM_AW-1:0] byteA,
  input  logic [RAM_AW-1:0] regA,
  input  logic [RAM_AW-1:0] popA,
  input  logic [RAM_AW-1:0] bitA,
  output byte_t             ptrRaw,
  output byte_t             byteRaw,
  output byte_t             regRaw,
  output byte_t             popRaw,
  output byte_t             bitByteRaw
);
  byte_t mem [RAM_BYTES];

  logic [RAM_BYTES-1:0] byteHit;
  logic [RAM_BYTES-1:0] regHit;
  logic [RAM_BYTES-1:0] pushHit;
  logic [RAM_BYTES-1:0] bitHit;

  // one-hot decode of every writer per byte
  for (genvar g = 0; g < RAM_BYTES; g++) begin : g_hit
    assign byteHit[g] = wr.byteWe && (wr.byteA == RAM_AW'(g));
    assign regHit[g]  = wr.regWe  && (wr.regA  == RAM_AW'(g));
    assign pushHit[g] = wr.pushWe && (wr.pushA == RAM_AW'(g));
    assign bitHit[g]  = wr.bitWe  && (wr.bitA  == RAM_AW'(g));
  end

  // fixed priority per byte: byte port, register, push, bit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < RAM_BYTES; i++) mem[i] <= '0;
    end else begin
      for (int i = 0; i < RAM_BYTES; i++) begin
        if (byteHit[i])      mem[i] <= wr.byteD;
        else if (regHit[i])  mem[i] <= wr.regD;
        else if (pushHit[i]) mem[i] <= wr.pushD;
        else if (bitHit[i])  mem[i][wr.bitPos] <= wr.bitVal;
      end
    end
  end

  assign ptrRaw     = mem[ptrA];
  assign byteRaw    = mem[byteA];
  assign regRaw     = mem[regA];
  assign popRaw     = mem[popA];
  assign bitByteRaw = mem[bitA];
endmodule

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
  import bitram_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] byteAddr,
  input  logic              byteInd,
  input  logic              byteWrEn,
  input  byte_t             byteWrData,
  input  logic [REG_W-1:0]  regSel,
  input  logic [BANK_W-1:0] bankSel,
  input  logic              bankWrEn,
  input  logic              regWrEn,
  input  byte_t             regWrData,
  input  logic [BIT_AW-1:0] bitAddr,
  input  logic [1:0]        bitOp,
  input  logic              bitWrData,
  input  logic              pushEn,
  input  byte_t             pushData,
  input  logic              popEn,
  input  logic              spLoadEn,
  input  logic [ADDR_W-1:0] spLoadData,
  input  byte_t             ptrRaw,
  input  byte_t             byteRaw,
  input  byte_t             popRaw,
  input  byte_t             bitByteRaw,
  output logic [RAM_AW-1:0] ptrA,
  output logic [RAM_AW-1:0] byteA,
  output logic [RAM_AW-1:0] regA,
  output logic [RAM_AW-1:0] popA,
  output logic [RAM_AW-1:0] bitA,
  output wrStrobes_t        wr,
  output byte_t             byteRdData,
  output logic              bitRdData,
  output byte_t             popData,
  output logic [BANK_W-1:0] curBank,
  output logic [ADDR_W-1:0] spOut
);
  localparam logic [ADDR_W-1:0] RAM_LIMIT  = ADDR_W'(RAM_BYTES);
  localparam logic [RAM_AW-1:0] BIT_BASE_A = RAM_AW'(BIT_BASE);

  logic [BANK_W-1:0] bankQ;
  logic [ADDR_W-1:0] spQ;
  logic [ADDR_W-1:0] spNext;
  logic [ADDR_W-1:0] effAddr;
  logic [ADDR_W-1:0] pushAddr;
  logic              byteOk;
  logic              pushOk;
  logic              popOk;
  logic              takePush;
  logic              takePop;
  logic              bitValNext;
  bitOp_e            op;

  // bank register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         bankQ <= '0;
    else if (bankWrEn) bankQ <= bankSel;
  end

  // address resolution for the byte and register ports
  assign ptrA    = RAM_AW'({bankQ, REG_W'(byteAddr[0])});
  assign effAddr = byteInd ? ptrRaw : byteAddr;
  assign byteOk  = effAddr < RAM_LIMIT;
  assign byteA   = RAM_AW'(effAddr);
  assign regA    = RAM_AW'({bankQ, regSel});

  // bit window mapping
  assign bitA = BIT_BASE_A + RAM_AW'(bitAddr[BIT_AW-1:POS_W]);
  assign op   = bitOp_e'(bitOp);

  always_comb begin
    unique case (op)
      BIT_SET: bitValNext = 1'b1;
      BIT_CLR: bitValNext = 1'b0;
      BIT_PUT: bitValNext = bitWrData;
      default: bitValNext = 1'b0;
    endcase
  end

  // stack pointer: load beats push, push beats pop
  assign takePush = pushEn && !spLoadEn;
  assign takePop  = popEn && !pushEn && !spLoadEn;
  assign pushAddr = spQ + ADDR_W'(1);
  assign pushOk   = pushAddr < RAM_LIMIT;
  assign popOk    = spQ < RAM_LIMIT;
  assign popA     = RAM_AW'(spQ);

  always_comb begin
    spNext = spQ;
    if (spLoadEn)      spNext = spLoadData;
    else if (takePush) spNext = pushAddr;
    else if (takePop)  spNext = spQ - ADDR_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) spQ <= SP_INIT;
    else       spQ <= spNext;
  end

  // strobe bundle to the datapath
  always_comb begin
    wr        = '0;
    wr.byteWe = byteWrEn && byteOk;
    wr.byteA  = byteA;
    wr.byteD  = byteWrData;
    wr.regWe  = regWrEn;
    wr.regA   = regA;
    wr.regD   = regWrData;
    wr.pushWe = takePush && pushOk;
    wr.pushA  = RAM_AW'(pushAddr);
    wr.pushD  = pushData;
    wr.bitWe  = (op != BIT_NOP);
    wr.bitA   = bitA;
    wr.bitPos = bitAddr[POS_W-1:0];
    wr.bitVal = bitValNext;
  end

  // read-side gating
  assign byteRdData = byteOk ? byteRaw : '0;
  assign popData    = popOk ? popRaw : '0;
  assign bitRdData  = bitByteRaw[bitAddr[POS_W-1:0]];
  assign curBank    = bankQ;
  assign spOut      = spQ;
endmodule

// File: rtl/bitram_core.sv
module bitram_core
  import bitram_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [7:0]  byteAddr,
  input  logic        byteInd,
  input  logic        byteWrEn,
  input  logic [7:0]  byteWrData,
  output logic [7:0]  byteRdData,
  input  logic [2:0]  regSel,
  input  logic [1:0]  bankSel,
  input  logic        bankWrEn,
  output logic [1:0]  curBank,
  input  logic        regWrEn,
  input  logic [7:0]  regWrData,
  output logic [7:0]  regRdData,
  input  logic [6:0]  bitAddr,
  input  logic [1:0]  bitOp,
  input  logic        bitWrData,
  output logic        bitRdData,
  input  logic        pushEn,
  input  logic [7:0]  pushData,
  input  logic        popEn,
  output logic [7:0]  popData,
  input  logic        spLoadEn,
  input  logic [7:0]  spLoadData,
  output logic [7:0]  spOut
);
  wrStrobes_t        wr;
  logic [RAM_AW-1:0] ptrA;
  logic [RAM_AW-1:0] byteA;
  logic [RAM_AW-1:0] regA;
  logic [RAM_AW-1:0] popA;
  logic [RAM_AW-1:0] bitA;
  byte_t             ptrRaw;
  byte_t             byteRaw;
  byte_t             popRaw;
  byte_t             bitByteRaw;

  bitram_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .byteAddr   (byteAddr),
    .byteInd    (byteInd),
    .byteWrEn   (byteWrEn),
    .byteWrData (byteWrData),
    .regSel     (regSel),
    .bankSel    (bankSel),
    .bankWrEn   (bankWrEn),
    .regWrEn    (regWrEn),
    .regWrData  (regWrData),
    .bitAddr    (bitAddr),
    .bitOp      (bitOp),
    .bitWrData  (bitWrData),
    .pushEn     (pushEn),
    .pushData   (pushData),
    .popEn      (popEn),
    .spLoadEn   (spLoadEn),
    .spLoadData (spLoadData),
    .ptrRaw     (ptrRaw),
    .byteRaw    (byteRaw),
    .popRaw     (popRaw),
    .bitByteRaw (bitByteRaw),
    .ptrA       (ptrA),
    .byteA      (byteA),
    .regA       (regA),
    .popA       (popA),
    .bitA       (bitA),
    .wr         (wr),
    .byteRdData (byteRdData),
    .bitRdData  (bitRdData),
    .popData    (popData),
    .curBank    (curBank),
    .spOut      (spOut)
  );

  bitram_dpath dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .wr         (wr),
    .ptrA       (ptrA),
    .byteA      (byteA),
    .regA       (regA),
    .popA       (popA),
    .bitA       (bitA),
    .ptrRaw     (ptrRaw),
    .byteRaw    (byteRaw),
    .regRaw     (regRdData),
    .popRaw     (popRaw),
    .bitByteRaw (bitByteRaw)
  );
endmodule

// File: rtl/bitram_chk.sv
module bitram_chk (
  input logic       clk,
  input logic       rstN,
  input logic [7:0] byteAddr,
  input logic       byteInd,
  input logic       byteWrEn,
  input logic [7:0] byteWrData,
  input logic [7:0] byteRdData,
  input logic [1:0] bankSel,
  input logic       bankWrEn,
  input logic [1:0] curBank,
  input logic       regWrEn,
  input logic [6:0] bitAddr,
  input logic [1:0] bitOp,
  input logic       bitRdData,
  input logic       pushEn,
  input logic       popEn,
  input logic [7:0] popData,
  input logic       spLoadEn,
  input logic [7:0] spLoadData,
  input logic [7:0] spOut
);
  // R1
  byte_wr_rd_chk: assert property (@(posedge clk) disable iff (!rstN)
    (byteWrEn && !byteInd && byteAddr < 8'h80)
      |=> (byteInd || byteAddr != $past(byteAddr) || byteRdData == $past(byteWrData)));

  // R2
  oor_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!byteInd && byteAddr >= 8'h80) |-> (byteRdData == 8'h00));

  // R5
  bank_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    bankWrEn |=> (curBank == $past(bankSel)));

  // R5
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bankWrEn |=> $stable(curBank));

  // R7
  bit_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bitOp == 2'b01 && !byteWrEn && !regWrEn && !pushEn)
      |=> (bitAddr != $past(bitAddr) || bitRdData));

  // R9
  sp_push_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pushEn && !spLoadEn) |=> (spOut == 8'($past(spOut) + 8'd1)));

  // R10
  sp_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popEn && !pushEn && !spLoadEn) |=> (spOut == 8'($past(spOut) - 8'd1)));

  // R10
  pop_oor_chk: assert property (@(posedge clk) disable iff (!rstN)
    (spOut >= 8'h80) |-> (popData == 8'h00));

  // R11
  sp_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    spLoadEn |=> (spOut == $past(spLoadData)));

  // R11
  sp_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!spLoadEn && !pushEn && !popEn) |=> $stable(spOut));
endmodule

bind bitram_core bitram_chk chk_i (.*);

// File: tb/bitram_core_tb_top.sv
`timescale 1ns/1ps
module bitram_core_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [7:0] byteAddr;
  logic       byteInd;
  logic       byteWrEn;
  logic [7:0] byteWrData;
  logic [7:0] byteRdData;
  logic [2:0] regSel;
  logic [1:0] bankSel;
  logic       bankWrEn;
  logic [1:0] curBank;
  logic       regWrEn;
  logic [7:0] regWrData;
  logic [7:0] regRdData;
  logic [6:0] bitAddr;
  logic [1:0] bitOp;
  logic       bitWrData;
  logic       bitRdData;
  logic       pushEn;
  logic [7:0] pushData;
  logic       popEn;
  logic [7:0] popData;
  logic       spLoadEn;
  logic [7:0] spLoadData;
  logic [7:0] spOut;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  bitram_core dut_i (.*);

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    byteAddr = '0; byteInd = 0; byteWrEn = 0; byteWrData = '0;
    regSel = '0; bankSel = '0; bankWrEn = 0; regWrEn = 0; regWrData = '0;
    bitAddr = '0; bitOp = 2'b00; bitWrData = 0;
    pushEn = 0; pushData = '0; popEn = 0; spLoadEn = 0; spLoadData = '0;
  endtask

  task automatic wrByte(input logic [7:0] a, input logic [7:0] d);
    byteInd = 0; byteAddr = a; byteWrData = d; byteWrEn = 1;
    tick();
    byteWrEn = 0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    byteInd = 0; byteAddr = a;
    #1 d = byteRdData;
  endtask

  task automatic setBank(input logic [1:0] b);
    bankSel = b; bankWrEn = 1;
    tick();
    bankWrEn = 0;
  endtask

  task automatic loadSp(input logic [7:0] v);
    spLoadData = v; spLoadEn = 1;
    tick();
    spLoadEn = 0;
  endtask

  task automatic doBit(input logic [6:0] a, input logic [1:0] op, input logic v);
    bitAddr = a; bitOp = op; bitWrData = v;
    tick();
    bitOp = 2'b00;
  endtask

  task automatic tResetState();
    logic [7:0] d;
    chk("R9 sp after reset", spOut, 8'h07);
    chk("R5 bank after reset", {6'b0, curBank}, 8'h00);
    peek(8'h45, d); chk("R12 byte 45 after reset", d, 8'h00);
    peek(8'h00, d); chk("R12 byte 00 after reset", d, 8'h00);
    chk("R10 popData after reset", popData, 8'h00);
  endtask

  task automatic tByteDirect();
    logic [7:0] d;
    wrByte(8'h00, 8'hA5);
    wrByte(8'h7F, 8'h3C);
    wrByte(8'h30, 8'h5A);
    peek(8'h00, d); chk("R1 byte 00", d, 8'hA5);
    peek(8'h7F, d); chk("R1 byte 7F", d, 8'h3C);
    peek(8'h30, d); chk("R1 byte 30", d, 8'h5A);
    byteAddr = 8'h30; byteWrData = 8'h11; byteWrEn = 1;
    #1 chk("R1 old value before edge", byteRdData, 8'h5A);
    tick();
    byteWrEn = 0;
    #1 chk("R1 new value after edge", byteRdData, 8'h11);
  endtask

  task automatic tOutOfRange();
    logic [7:0] d;
    wrByte(8'h80, 8'hFF);
    peek(8'h80, d); chk("R2 read 80", d, 8'h00);
    peek(8'h00, d); chk("R2 byte 00 untouched", d, 8'hA5);
    wrByte(8'hFF, 8'hEE);
    peek(8'h7F, d); chk("R2 byte 7F untouched", d, 8'h3C);
    peek(8'hFF, d); chk("R2 read FF", d, 8'h00);
  endtask

  task automatic tBanks();
    logic [7:0] d;
    setBank(2'd2);
    chk("R5 bank loaded", {6'b0, curBank}, 8'h02);
    regSel = 3'd3; regWrData = 8'h77; regWrEn = 1;
    tick();
    regWrEn = 0;
    peek(8'h13, d); chk("R4 bank2 reg3 at 13", d, 8'h77);
    bankSel = 2'd1;
    tick();
    chk("R5 bank held without strobe", {6'b0, curBank}, 8'h02);
    regSel = 3'd3;
    #1 chk("R4 register read bank2", regRdData, 8'h77);
    setBank(2'd0);
    regSel = 3'd0;
    #1 chk("R4 bank0 reg0 is byte 00", regRdData, 8'hA5);
    setBank(2'd3);
    regSel = 3'd7; regWrData = 8'h5C; regWrEn = 1;
    tick();
    regWrEn = 0;
    peek(8'h1F, d); chk("R4 bank3 reg7 at 1F", d, 8'h5C);
    setBank(2'd0);
  endtask

  task automatic tIndirect();
    logic [7:0] d;
    setBank(2'd1);
    regSel = 3'd1; regWrData = 8'h45; regWrEn = 1;
    tick();
    regWrEn = 0;
    byteInd = 1; byteAddr = 8'h01; byteWrData = 8'h99; byteWrEn = 1;
    tick();
    byteWrEn = 0;
    #1 chk("R3 indirect read via reg1", byteRdData, 8'h99);
    peek(8'h45, d); chk("R3 indirect write landed at 45", d, 8'h99);
    regSel = 3'd0; regWrData = 8'h90; regWrEn = 1;
    tick();
    regWrEn = 0;
    byteInd = 1; byteAddr = 8'h00; byteWrData = 8'hAB; byteWrEn = 1;
    #1 chk("R2 indirect read above 7F", byteRdData, 8'h00);
    tick();
    byteWrEn = 0;
    peek(8'h10, d); chk("R2 indirect write above 7F dropped", d, 8'h00);
    setBank(2'd0);
  endtask

  task automatic tBitOps();
    logic [7:0] d;
    wrByte(8'h21, 8'h00);
    doBit(7'h0A, 2'b01, 1'b0);
    peek(8'h21, d); chk("R7 set bit 0A", d, 8'h04);
    bitAddr = 7'h0A;
    #1 chk("R6 bit 0A reads 1", {7'b0, bitRdData}, 8'h01);
    bitAddr = 7'h0B;
    #1 chk("R6 bit 0B reads 0", {7'b0, bitRdData}, 8'h00);
    wrByte(8'h2F, 8'hFF);
    doBit(7'h7F, 2'b10, 1'b1);
    peek(8'h2F, d); chk("R7 clear bit 7F", d, 8'h7F);
    doBit(7'h78, 2'b11, 1'b0);
    peek(8'h2F, d); chk("R7 write 0 to bit 78", d, 8'h7E);
    doBit(7'h78, 2'b11, 1'b1);
    peek(8'h2F, d); chk("R7 write 1 to bit 78", d, 8'h7F);
    doBit(7'h79, 2'b00, 1'b0);
    peek(8'h2F, d); chk("R7 no-op leaves byte", d, 8'h7F);
    doBit(7'h00, 2'b01, 1'b0);
    peek(8'h20, d); chk("R6 bit 00 is byte 20 bit 0", d, 8'h01);
  endtask

  task automatic tPriority();
    logic [7:0] d;
    byteAddr = 8'h22; byteWrData = 8'hF0; byteWrEn = 1;
    bitAddr = 7'h10; bitOp = 2'b01;
    tick();
    byteWrEn = 0; bitOp = 2'b00;
    peek(8'h22, d); chk("R8 byte write beats bit set", d, 8'hF0);
    byteAddr = 8'h24; byteWrData = 8'h0F; byteWrEn = 1;
    bitAddr = 7'h28; bitOp = 2'b01;
    tick();
    byteWrEn = 0; bitOp = 2'b00;
    peek(8'h24, d); chk("R13 byte write to other byte", d, 8'h0F);
    peek(8'h25, d); chk("R13 bit set to other byte", d, 8'h01);
    setBank(2'd3);
    loadSp(8'h1E);
    regSel = 3'd7; regWrData = 8'h11; regWrEn = 1;
    pushData = 8'h22; pushEn = 1;
    tick();
    regWrEn = 0; pushEn = 0;
    peek(8'h1F, d); chk("R13 register beats push", d, 8'h11);
    chk("R9 sp moved by push", spOut, 8'h1F);
    loadSp(8'h22);
    pushData = 8'h5A; pushEn = 1;
    bitAddr = 7'h18; bitOp = 2'b11; bitWrData = 1;
    tick();
    pushEn = 0; bitOp = 2'b00;
    peek(8'h23, d); chk("R13 push beats bit write", d, 8'h5A);
    setBank(2'd0);
  endtask

  task automatic tStack();
    logic [7:0] d;
    loadSp(8'h07);
    pushData = 8'h11; pushEn = 1;
    tick();
    pushEn = 0;
    chk("R9 first push moves sp to 08", spOut, 8'h08);
    peek(8'h08, d); chk("R9 first push at 08", d, 8'h11);
    pushData = 8'h22; pushEn = 1;
    tick();
    pushEn = 0;
    #1 chk("R10 popData shows top", popData, 8'h22);
    popEn = 1;
    tick();
    popEn = 0;
    chk("R10 pop decrements sp", spOut, 8'h08);
    #1 chk("R10 popData after pop", popData, 8'h11);
    loadSp(8'h00);
    popEn = 1;
    tick();
    popEn = 0;
    chk("R10 pop wraps to FF", spOut, 8'hFF);
    #1 chk("R10 popData above 7F", popData, 8'h00);
    pushData = 8'h66; pushEn = 1;
    tick();
    pushEn = 0;
    chk("R9 push wraps to 00", spOut, 8'h00);
    peek(8'h00, d); chk("R9 wrapped push at 00", d, 8'h66);
    loadSp(8'h7F);
    pushData = 8'hEE; pushEn = 1;
    tick();
    pushEn = 0;
    chk("R9 push to 80", spOut, 8'h80);
    peek(8'h00, d); chk("R2 push at 80 dropped, 00 kept", d, 8'h66);
    peek(8'h7F, d); chk("R2 push at 80 dropped, 7F kept", d, 8'h3C);
  endtask

  task automatic tSpLoad();
    logic [7:0] d;
    loadSp(8'h50);
    spLoadData = 8'h40; spLoadEn = 1; pushData = 8'hC3; pushEn = 1; popEn = 1;
    tick();
    spLoadEn = 0; pushEn = 0; popEn = 0;
    chk("R11 load overrides push and pop", spOut, 8'h40);
    peek(8'h51, d); chk("R11 suppressed push wrote nothing", d, 8'h00);
    spLoadData = 8'h30; spLoadEn = 1; popEn = 1;
    tick();
    spLoadEn = 0; popEn = 0;
    chk("R11 load overrides pop", spOut, 8'h30);
    pushData = 8'h9D; pushEn = 1; popEn = 1;
    tick();
    pushEn = 0; popEn = 0;
    chk("R11 push wins over pop", spOut, 8'h31);
    peek(8'h31, d); chk("R11 push data written", d, 8'h9D);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    tResetState();
    tByteDirect();
    tOutOfRange();
    tBanks();
    tIndirect();
    tBitOps();
    tPriority();
    tStack();
    tSpLoad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule